// File: doc/BRIEF.md
# Load Address Generation with Latency Classing

This block sits in a load pipeline between rename and the data cache. Each decoded load presents a base register value, an optional scaled index register value, a two-bit scale code, a signed displacement and a tag. The block adds these into a 64-bit effective address. It also sorts the load into one of two address-generation paths. Loads whose addressing form is cheap take the fast path. Every other form pays one extra cycle on the slow path.

A load is fast when it uses a base register and a displacement between 0 and 2047 inclusive, and either names no index or names an index that rename has marked as known zero through a recognized zeroing idiom. Each result leaves through a short delay line at the latency of its class. A younger fast load that would land in the same output cycle as an older slow load is held at the request handshake for one cycle.

Top module: `agu_load_latency`

## Requirements
- R1: A load with `req_idx_present` low and a displacement in 0..2047 inclusive is fast (`res_slow` = 0).
- R2: A displacement that is negative or greater than 2047 makes the load slow (`res_slow` = 1), whatever the index fields hold.
- R3: A load with `req_idx_present` high and `req_idx_known_zero` low is slow, for every scale code.
- R4: A load with `req_idx_present` high, `req_idx_known_zero` high and a displacement in 0..2047 is fast.
- R5: An index whose value is literally zero but whose known-zero flag is low still makes the load slow.
- R6: `res_addr` = base + (index << scale) + sign-extended displacement, modulo 2^64. Scale code 0,1,2,3 means a multiplier of 1,2,4,8. The index term is zero when `req_idx_present` is low, whatever `req_index` and `req_idx_known_zero` hold.
- R7: A request is accepted at a rising edge where `req_valid` and `req_ready` are both high. If the accepting edge is k, then `res_valid` is sampled high at edge k+4 for a fast load and at edge k+5 for a slow load, with that load's tag. It is sampled low at the edges in between.
- R8: `req_ready` is low only when a fast request is offered while an older slow load would leave in the same cycle. A slow request is never held. No two results ever share an output cycle.
- R9: After reset `res_valid` is low and `req_ready` is high.
- R10: Loads of the same class leave in the order they were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Load request valid |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_base | input | ADDR_W | Base register value |
| req_index | input | ADDR_W | Index register value |
| req_idx_present | input | 1 | The load names an index register |
| req_idx_known_zero | input | 1 | Rename marks the index as zeroed by an idiom |
| req_scale | input | 2 | Index shift amount (multiplier 1/2/4/8) |
| req_disp | input | DISP_W | Signed displacement |
| req_tag | input | TAG_W | Load identifier |
| res_valid | output | 1 | Result valid |
| res_addr | output | ADDR_W | Effective address |
| res_tag | output | TAG_W | Tag of the completing load |
| res_slow | output | 1 | Load took the slow path |

## Verification
The bench builds the block with its defaults: a 64-bit address, a 32-bit displacement, a 2047 fast limit, and latencies of 4 and 5 cycles. A 32-bit displacement lets the bench drive the values on both sides of the 2047 limit and negative values. A 64-bit base near the top of the address space exercises the wrap-around. Because the two latencies differ by a single cycle, a slow load followed directly by a fast load gives exactly one stall cycle. Mixed sequences therefore show both the held request and the ordering of the two classes at the output.

// File: rtl/agu_lat_pkg.sv
// Shared types for the load address-generation latency block.
// Assumes nothing beyond IEEE 1800-2017 packages.
package agu_lat_pkg;
    typedef enum logic {
        LAT_FAST = 1'b0,
        LAT_SLOW = 1'b1
    } lat_class_e;
endpackage

// File: rtl/agu_form_classifier.sv
// Decides the latency class of a load from its addressing form.
// Assumes the displacement is two's complement and SIMPLE_MAX fits in it.
module agu_form_classifier
    import agu_lat_pkg::*;
#(
    parameter int DISP_W     = 32,
    parameter int SIMPLE_MAX = 2047
) (
    input  logic [DISP_W-1:0] disp,
    input  logic              idx_present,
    input  logic              idx_known_zero,
    output lat_class_e        cls
);
    localparam logic [DISP_W-1:0] LIMIT = DISP_W'(SIMPLE_MAX);

    logic disp_in_range;
    logic idx_costs;

    // Displacement must be non-negative and no larger than the limit.
    always_comb disp_in_range = !disp[DISP_W-1] && (disp <= LIMIT);

    // An index only costs the extra cycle when rename cannot prove it zero.
    always_comb idx_costs = idx_present && !idx_known_zero;

    // Fast path only when both conditions allow it.
    always_comb cls = (disp_in_range && !idx_costs) ? LAT_FAST : LAT_SLOW;
endmodule

// File: rtl/agu_ea_adder.sv
// Computes base + scaled index + sign-extended displacement, wrapping at ADDR_W.
// Assumes DISP_W < ADDR_W.
module agu_ea_adder #(
    parameter int ADDR_W = 64,
    parameter int DISP_W = 32
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] index,
    input  logic              idx_present,
    input  logic [1:0]        scale,
    input  logic [DISP_W-1:0] disp,
    output logic [ADDR_W-1:0] addr
);
    localparam int EXT_W = ADDR_W - DISP_W;

    logic [ADDR_W-1:0] idx_term;
    logic [ADDR_W-1:0] disp_ext;

    // Scaled index, dropped when the form has no index register.
    always_comb idx_term = idx_present ? (index << scale) : '0;

    // Sign-extend the displacement to the address width.
    always_comb disp_ext = {{EXT_W{disp[DISP_W-1]}}, disp};

    // Three-input sum; carries out of the top bit are discarded.
    always_comb addr = base + idx_term + disp_ext;
endmodule

// File: rtl/agu_result_pipe.sv
// Delay line that releases each result after its class latency.
// Slow entries enter the first slot, fast entries enter a later slot so both
// exit from the last slot. Assumes SLOW_LAT > FAST_LAT >= 1, and that the
// caller never inserts a fast entry while fast_blocked is high.
module agu_result_pipe #(
    parameter int ADDR_W   = 64,
    parameter int TAG_W    = 4,
    parameter int FAST_LAT = 4,
    parameter int SLOW_LAT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ins_valid,
    input  logic              ins_slow,
    input  logic [ADDR_W-1:0] ins_addr,
    input  logic [TAG_W-1:0]  ins_tag,
    output logic              fast_blocked,
    output logic              out_valid,
    output logic              out_slow,
    output logic [ADDR_W-1:0] out_addr,
    output logic [TAG_W-1:0]  out_tag
);
    localparam int FAST_SLOT = SLOW_LAT - FAST_LAT + 1;

    logic [SLOW_LAT:1] stg_v;
    logic [SLOW_LAT:1] stg_slow;
    logic [ADDR_W-1:0] stg_addr [1:SLOW_LAT];
    logic [TAG_W-1:0]  stg_tag  [1:SLOW_LAT];

    logic put_slow;
    logic put_fast;

    // Split the insert by class.
    always_comb put_slow = ins_valid && ins_slow;
    always_comb put_fast = ins_valid && !ins_slow;

    for (genvar s = 1; s <= SLOW_LAT; s++) begin : g_slot
        if (s == 1) begin : g_head
            // Head slot: only slow entries are written here.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg_v[s] <= 1'b0;
                end else begin
                    stg_v[s] <= put_slow;
                end
                stg_slow[s] <= 1'b1;
                stg_addr[s] <= ins_addr;
                stg_tag[s]  <= ins_tag;
            end
        end else if (s == FAST_SLOT) begin : g_fast_entry
            // Fast insert slot: takes a new fast entry or the one behind it.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg_v[s] <= 1'b0;
                end else begin
                    stg_v[s] <= put_fast || stg_v[s-1];
                end
                if (put_fast) begin
                    stg_slow[s] <= 1'b0;
                    stg_addr[s] <= ins_addr;
                    stg_tag[s]  <= ins_tag;
                end else begin
                    stg_slow[s] <= stg_slow[s-1];
                    stg_addr[s] <= stg_addr[s-1];
                    stg_tag[s]  <= stg_tag[s-1];
                end
            end
        end else begin : g_shift
            // Plain shift slot.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stg_v[s] <= 1'b0;
                end else begin
                    stg_v[s] <= stg_v[s-1];
                end
                stg_slow[s] <= stg_slow[s-1];
                stg_addr[s] <= stg_addr[s-1];
                stg_tag[s]  <= stg_tag[s-1];
            end
        end
    end

    // A fast entry would collide with the slot moving into its insert point.
    always_comb fast_blocked = stg_v[FAST_SLOT-1];

    // Last slot drives the block outputs.
    always_comb begin
        out_valid = stg_v[SLOW_LAT];
        out_slow  = stg_slow[SLOW_LAT];
        out_addr  = stg_addr[SLOW_LAT];
        out_tag   = stg_tag[SLOW_LAT];
    end
endmodule

// File: rtl/agu_load_latency.sv
// Top level: classifies each load, computes its address and returns it after
// the latency of its class. Holds a fast request for a cycle when its result
// would land on the same output cycle as an older slow one.
// Assumes SLOW_LAT > FAST_LAT and DISP_W < ADDR_W.
module agu_load_latency
    import agu_lat_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int DISP_W     = 32,
    parameter int TAG_W      = 4,
    parameter int SIMPLE_MAX = 2047,
    parameter int FAST_LAT   = 4,
    parameter int SLOW_LAT   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_base,
    input  logic [ADDR_W-1:0] req_index,
    input  logic              req_idx_present,
    input  logic              req_idx_known_zero,
    input  logic [1:0]        req_scale,
    input  logic [DISP_W-1:0] req_disp,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              res_valid,
    output logic [ADDR_W-1:0] res_addr,
    output logic [TAG_W-1:0]  res_tag,
    output logic              res_slow
);
    lat_class_e        req_cls;
    logic              req_is_slow;
    logic [ADDR_W-1:0] ea;
    logic              fast_blocked;
    logic              accept;

    agu_form_classifier #(
        .DISP_W     (DISP_W),
        .SIMPLE_MAX (SIMPLE_MAX)
    ) u_class (
        .disp           (req_disp),
        .idx_present    (req_idx_present),
        .idx_known_zero (req_idx_known_zero),
        .cls            (req_cls)
    );

    agu_ea_adder #(
        .ADDR_W (ADDR_W),
        .DISP_W (DISP_W)
    ) u_ea (
        .base        (req_base),
        .index       (req_index),
        .idx_present (req_idx_present),
        .scale       (req_scale),
        .disp        (req_disp),
        .addr        (ea)
    );

    // Class as a plain bit for the delay line.
    always_comb req_is_slow = (req_cls == LAT_SLOW);

    // Hold only a fast request whose result slot is already claimed.
    always_comb req_ready = !(!req_is_slow && fast_blocked);

    // Handshake completes when both sides agree.
    always_comb accept = req_valid && req_ready;

    agu_result_pipe #(
        .ADDR_W   (ADDR_W),
        .TAG_W    (TAG_W),
        .FAST_LAT (FAST_LAT),
        .SLOW_LAT (SLOW_LAT)
    ) u_pipe (
        .clk          (clk),
        .rst_n        (rst_n),
        .ins_valid    (accept),
        .ins_slow     (req_is_slow),
        .ins_addr     (ea),
        .ins_tag      (req_tag),
        .fast_blocked (fast_blocked),
        .out_valid    (res_valid),
        .out_slow     (res_slow),
        .out_addr     (res_addr),
        .out_tag      (res_tag)
    );
endmodule

// File: rtl/agu_load_latency_chk.sv
// Protocol and classification checks for agu_load_latency, bound to every
// instance. Keeps its own count of loads in flight.
module agu_load_latency_chk #(
    parameter int DISP_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [DISP_W-1:0] req_disp,
    input logic              idx_present,
    input logic              idx_zero,
    input logic              is_slow,
    input logic              res_valid
);
    int   inflight;
    logic fresh;

    // Count accepted loads that have not yet produced a result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inflight <= 0;
        end else begin
            inflight <= inflight + ((req_valid && req_ready) ? 1 : 0) - (res_valid ? 1 : 0);
        end
    end

    // Marks the first active edge after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) fresh <= 1'b1;
        else        fresh <= 1'b0;
    end

    a_r8_slow_never_held: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && is_slow) |-> req_ready);

    a_r3_unproven_index_slow: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && idx_present && !idx_zero) |-> is_slow);

    a_r2_negative_disp_slow: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_disp[DISP_W-1]) |-> is_slow);

    a_r7_result_has_source: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (inflight > 0));

    a_r9_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        fresh |-> (!res_valid && req_ready));
endmodule

bind agu_load_latency agu_load_latency_chk #(
    .DISP_W (DISP_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_disp    (req_disp),
    .idx_present (req_idx_present),
    .idx_zero    (req_idx_known_zero),
    .is_slow     (req_is_slow),
    .res_valid   (res_valid)
);

// File: tb/agu_load_latency_test.sv
// Directed bench for agu_load_latency: one task per scenario.
module agu_load_latency_test;
    localparam int AW = 64;
    localparam int DW = 32;
    localparam int TW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_base = '0;
    logic [AW-1:0] req_index = '0;
    logic          req_idx_present = 1'b0;
    logic          req_idx_known_zero = 1'b0;
    logic [1:0]    req_scale = '0;
    logic [DW-1:0] req_disp = '0;
    logic [TW-1:0] req_tag = '0;
    logic          res_valid;
    logic [AW-1:0] res_addr;
    logic [TW-1:0] res_tag;
    logic          res_slow;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    int            lg_edge [32];
    logic [TW-1:0] lg_tag  [32];
    logic          lg_slow [32];
    logic [AW-1:0] lg_addr [32];
    int            lg_n = 0;

    agu_load_latency uut (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready),
        .req_base (req_base), .req_index (req_index),
        .req_idx_present (req_idx_present), .req_idx_known_zero (req_idx_known_zero),
        .req_scale (req_scale), .req_disp (req_disp), .req_tag (req_tag),
        .res_valid (res_valid), .res_addr (res_addr),
        .res_tag (res_tag), .res_slow (res_slow)
    );

    always #2 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Log each result with the edge at which it is sampled.
    always @(negedge clk) begin
        #1;
        if (rst_n && res_valid && lg_n < 32) begin
            lg_edge[lg_n] = cyc + 1;
            lg_tag[lg_n]  = res_tag;
            lg_slow[lg_n] = res_slow;
            lg_addr[lg_n] = res_addr;
            lg_n++;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Offer one request; wait while held. Returns accept edge and held cycles.
    task automatic issue(input logic [AW-1:0] b, input logic [AW-1:0] i,
                         input logic p, input logic z, input logic [1:0] sc,
                         input logic [DW-1:0] d, input logic [TW-1:0] t,
                         output int acc, output int held);
        @(negedge clk);
        req_base = b; req_index = i; req_idx_present = p;
        req_idx_known_zero = z; req_scale = sc; req_disp = d; req_tag = t;
        req_valid = 1'b1;
        held = 0;
        #1;
        while (!req_ready) begin
            held++;
            @(negedge clk);
            #1;
        end
        acc = cyc + 1;
        @(posedge clk);
    endtask

    task automatic drop();
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic drain();
        repeat (8) @(posedge clk);
        @(negedge clk);
        #2;
    endtask

    // Find a logged result by tag and check its timing and contents.
    task automatic expect_res(input string req, input logic [TW-1:0] t, input int acc,
                              input logic slow, input logic [AW-1:0] addr);
        int k = -1;
        int lat = slow ? 5 : 4;
        for (int n = 0; n < lg_n; n++) if (lg_tag[n] == t) k = n;
        chk(k >= 0, req, "result present", AW'(k), 0);
        if (k >= 0) begin
            chk(lg_edge[k] == acc + lat, req, "latency edge", AW'(lg_edge[k]), AW'(acc + lat));
            chk(lg_slow[k] == slow, req, "class", AW'(lg_slow[k]), AW'(slow));
            chk(lg_addr[k] == addr, req, "address", lg_addr[k], addr);
        end
    endtask

    task automatic single(input string req, input logic [AW-1:0] b, input logic [AW-1:0] i,
                          input logic p, input logic z, input logic [1:0] sc,
                          input logic [DW-1:0] d, input logic [TW-1:0] t,
                          input logic slow, input logic [AW-1:0] addr);
        int acc;
        int held;
        lg_n = 0;
        issue(b, i, p, z, sc, d, t, acc, held);
        drop();
        drain();
        chk(held == 0, req, "held cycles", AW'(held), 0);
        chk(lg_n == 1, req, "result count", AW'(lg_n), 1);
        expect_res(req, t, acc, slow, addr);
    endtask

    task automatic t_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(res_valid == 1'b0, "R9", "res_valid after reset", AW'(res_valid), 0);
        chk(req_ready == 1'b1, "R9", "req_ready after reset", AW'(req_ready), 1);
    endtask

    task automatic t_displacements();
        single("R1", 64'h1000, 64'h0, 1'b0, 1'b0, 2'd0, 32'd0, 4'd1, 1'b0, 64'h1000);
        single("R1", 64'h2000, 64'h0, 1'b0, 1'b0, 2'd0, 32'd2047, 4'd2, 1'b0, 64'h27FF);
        single("R2", 64'h2000, 64'h0, 1'b0, 1'b0, 2'd0, 32'd2048, 4'd3, 1'b1, 64'h2800);
        single("R2", 64'h100, 64'h0, 1'b0, 1'b0, 2'd0, 32'hFFFF_FFF8, 4'd4, 1'b1, 64'hF8);
    endtask

    task automatic t_two_regs();
        single("R3", 64'h1000, 64'd3, 1'b1, 1'b0, 2'd2, 32'd16, 4'd5, 1'b1, 64'h101C);
        single("R3", 64'h1000, 64'd5, 1'b1, 1'b0, 2'd3, 32'd0, 4'd6, 1'b1, 64'h1028);
        single("R3", 64'h1000, 64'd7, 1'b1, 1'b0, 2'd0, 32'd1, 4'd7, 1'b1, 64'h1008);
        single("R6", 64'h0, 64'd9, 1'b1, 1'b0, 2'd1, 32'd0, 4'd8, 1'b1, 64'h12);
    endtask

    task automatic t_zero_index();
        single("R4", 64'h4000, 64'h0, 1'b1, 1'b1, 2'd2, 32'd100, 4'd9, 1'b0, 64'h4064);
        single("R4", 64'h4000, 64'h0, 1'b1, 1'b1, 2'd2, 32'd3000, 4'd10, 1'b1, 64'h4BB8);
        single("R5", 64'h4000, 64'h0, 1'b1, 1'b0, 2'd2, 32'd100, 4'd11, 1'b1, 64'h4064);
    endtask

    task automatic t_address_math();
        single("R6", 64'hFFFF_FFFF_FFFF_FFF0, 64'h0, 1'b0, 1'b0, 2'd0, 32'h20, 4'd12, 1'b0, 64'h10);
        single("R6", 64'hFFFF_FFFF_FFFF_FFF8, 64'h1, 1'b1, 1'b0, 2'd3, 32'd0, 4'd13, 1'b1, 64'h0);
        single("R6", 64'h300, 64'h55, 1'b0, 1'b1, 2'd3, 32'd4, 4'd14, 1'b0, 64'h304);
    endtask

    // Slow then fast: fast is held one cycle and both land on distinct edges.
    task automatic t_collision();
        int a1, a2, h1, h2;
        lg_n = 0;
        issue(64'h500, 64'd1, 1'b1, 1'b0, 2'd0, 32'd0, 4'd1, a1, h1);
        issue(64'h600, 64'd0, 1'b0, 1'b0, 2'd0, 32'd8, 4'd2, a2, h2);
        drop();
        drain();
        chk(h1 == 0, "R8", "slow held", AW'(h1), 0);
        chk(h2 == 1, "R8", "fast held", AW'(h2), 1);
        chk(lg_n == 2, "R8", "result count", AW'(lg_n), 2);
        expect_res("R7", 4'd1, a1, 1'b1, 64'h501);
        expect_res("R7", 4'd2, a2, 1'b0, 64'h608);
    endtask

    // Fast then two slows then fast: slows never held, same-class order kept.
    task automatic t_mixed_stream();
        int a1, a2, a3, a4, h1, h2, h3, h4;
        lg_n = 0;
        issue(64'h10, 64'd0, 1'b0, 1'b0, 2'd0, 32'd0, 4'd3, a1, h1);
        issue(64'h20, 64'd2, 1'b1, 1'b0, 2'd0, 32'd0, 4'd4, a2, h2);
        issue(64'h30, 64'd3, 1'b1, 1'b0, 2'd0, 32'd0, 4'd5, a3, h3);
        issue(64'h40, 64'd0, 1'b0, 1'b0, 2'd0, 32'd1, 4'd6, a4, h4);
        drop();
        drain();
        chk(h2 == 0 && h3 == 0, "R8", "slow held cycles", AW'(h2 + h3), 0);
        chk(h4 == 1, "R8", "fast behind slow held", AW'(h4), 1);
        chk(lg_n == 4, "R10", "result count", AW'(lg_n), 4);
        expect_res("R7", 4'd3, a1, 1'b0, 64'h10);
        expect_res("R10", 4'd4, a2, 1'b0 ^ 1'b1, 64'h22);
        expect_res("R10", 4'd5, a3, 1'b1, 64'h33);
        expect_res("R7", 4'd6, a4, 1'b0, 64'h41);
        for (int n = 1; n < lg_n; n++)
            chk(lg_edge[n] > lg_edge[n-1], "R8", "distinct output edges",
                AW'(lg_edge[n]), AW'(lg_edge[n-1] + 1));
    endtask

    // Three fast loads back to back: no holds, consecutive exits in order.
    task automatic t_fast_burst();
        int a1, a2, a3, h1, h2, h3;
        lg_n = 0;
        issue(64'h100, 64'd0, 1'b0, 1'b0, 2'd0, 32'd1, 4'd7, a1, h1);
        issue(64'h100, 64'd0, 1'b0, 1'b0, 2'd0, 32'd2, 4'd8, a2, h2);
        issue(64'h100, 64'd0, 1'b0, 1'b0, 2'd0, 32'd3, 4'd9, a3, h3);
        drop();
        drain();
        chk(h1 + h2 + h3 == 0, "R8", "fast burst held", AW'(h1 + h2 + h3), 0);
        chk(lg_n == 3, "R10", "burst count", AW'(lg_n), 3);
        if (lg_n == 3)
            chk(lg_tag[0] == 4'd7 && lg_tag[1] == 4'd8 && lg_tag[2] == 4'd9,
                "R10", "burst order", {lg_tag[0], lg_tag[1], lg_tag[2]}, 12'h789);
        expect_res("R7", 4'd9, a3, 1'b0, 64'h103);
    endtask

    initial begin
        #(4 * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_displacements();
        t_two_regs();
        t_zero_index();
        t_address_math();
        t_collision();
        t_mixed_stream();
        t_fast_burst();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule